// File: doc/BRIEF.md
# PCI Initiator Termination Controller

This block is the initiator-side sequencer of a bridge that masters PCI cycles. It takes a request made of a start address, a word count and a direction, drives the active-low frame and initiator-ready strobes, and watches the target's device-select and target-ready lines. It ends each burst in one of two ways. A normal completion occurs on the last queued word, on a 4 KB page edge, on a full posted write buffer, or on an expired latency timer after the grant is withdrawn. A master abort occurs when no target claims the cycle in time.

A master abort also sets a sticky status bit that software clears by writing a one. The cause of the most recent termination is held on a small code output until the next termination. When a write completes and another write is already waiting, the next address phase follows with no idle clock between them.

Top module: `pci_mst_term`

## Requirements
- R1: After reset, frame_no and irdy_no are high, busy_o is low, mabort_sts_o is 0, term_cause_o is 0 and addr_o is 0.
- R2: A request accepted while idle (req_valid_i high, req_ack_o high) gives an address phase in the next clock (frame_no low, irdy_no high, addr_o equal to req_addr_i with bits [1:0] cleared). In the clock after that, irdy_no is low.
- R3: Clock 1 is the address phase. If devsel_ni is not sampled low in any of clocks 1 to 5, the burst ends with a master abort and term_cause_o = 5. If frame_no is still low, clock 6 shows frame_no high with irdy_no low and the bus is idle in clock 7. If frame_no was already high, the bus is idle in clock 6. A claim in clock 5 avoids the abort.
- R4: mabort_sts_o is set by every master abort and stays set. sts_we_i with sts_wdata_i = 1 clears it. sts_we_i with sts_wdata_i = 0 has no effect.
- R5: A data phase completes in a clock where irdy_no and trdy_ni are low and the target has claimed the cycle. Each completed phase adds 4 to addr_o.
- R6: When the remaining word count reaches 1, frame_no goes high in the same clock that irdy_no is low for that final phase, and term_cause_o = 1.
- R7: A data phase whose address has bits [11:2] all ones is the final one, and term_cause_o = 2.
- R8: For writes, wbuf_full_i high in the address phase or at a completed phase makes the next phase final, with term_cause_o = 3. For reads it is ignored.
- R9: The latency timer loads lat_val_i in the address phase and counts down once per clock to 0. When it reads 0 while gnt_ni is high, frame_no goes high in the next clock and term_cause_o = 4. With gnt_ni low, an expired timer has no effect.
- R10: irdy_no goes high, and busy_o low unless R11 applies, in the clock after the final phase completes.
- R11: If the final phase of a write completes while req_valid_i and req_write_i are high, the next clock is an address phase and busy_o does not drop in between.
- R12: When several normal causes apply to the same phase, the reported cause is the highest in this order: last word (1), page edge (2), buffer full (3), latency (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request pending |
| req_write_i | input | 1 | Request is a write |
| req_addr_i | input | ADDR_W | Start byte address |
| req_words_i | input | CNT_W | Words queued for the burst |
| req_ack_o | output | 1 | Request taken this clock |
| lat_val_i | input | LAT_W | Latency timer reload value |
| gnt_ni | input | 1 | Bus grant, active low |
| wbuf_full_i | input | 1 | Posted write buffer has no room |
| devsel_ni | input | 1 | Target claim, active low |
| trdy_ni | input | 1 | Target ready, active low |
| frame_no | output | 1 | Frame strobe, active low |
| irdy_no | output | 1 | Initiator ready, active low |
| busy_o | output | 1 | Burst in progress |
| addr_o | output | ADDR_W | Address of the current data phase |
| term_cause_o | output | 3 | Cause of the last termination (0 none, 1 last word, 2 page, 3 buffer full, 4 latency, 5 master abort) |
| sts_we_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 1 | Status write data, 1 clears |
| mabort_sts_o | output | 1 | Sticky received-master-abort flag |

## Verification
Every strobe, address, cause and status result is registered. Each one is therefore due exactly one clock after the edge that samples its stimulus. The bench drives inputs on the falling edge and holds a behavioural model that advances on the rising edge. It compares the outputs at the next falling edge, so each result is read in the clock it belongs to. Directed checks count the busy clocks of each burst to pin the abort window at clock 6 or 7. The same count confirms that irdy_no is released one clock after the final phase, and that no idle clock separates two writes run back to back.

// File: rtl/pci_mst_pkg.sv
package pci_mst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_DATA, ST_LAST, ST_ABORT
  } mst_state_e;

  typedef enum logic [2:0] {
    TC_NONE   = 3'd0,
    TC_LASTW  = 3'd1,
    TC_PAGE   = 3'd2,
    TC_WBUF   = 3'd3,
    TC_LAT    = 3'd4,
    TC_MABORT = 3'd5
  } term_cause_e;
endpackage

// File: rtl/pci_mst_lat_tmr.sv
module pci_mst_lat_tmr #(
  parameter int LAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LAT_W-1:0] val_i,
  input  logic             run_i,
  output logic             expired_o
);
  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= val_i;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - LAT_W'(1);
  end

  assign expired_o = (cnt_q == '0);

  a_r9_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(val_i));
  a_r9_never_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/pci_mst_dev_mon.sv
module pci_mst_dev_mon #(
  parameter int WIN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic active_i,
  input  logic devsel_ni,
  output logic claimed_o,
  output logic timeout_o
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] WIN_C = CW'(WIN);

  logic [CW-1:0] cnt_q;
  logic          claim_q;

  // cnt_q holds the clock index of the burst, 1 = address phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      claim_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= CW'(1);
      claim_q <= 1'b0;
    end else if (active_i) begin
      if (cnt_q != WIN_C) cnt_q <= cnt_q + CW'(1);
      if (!devsel_ni)     claim_q <= 1'b1;
    end
  end

  assign claimed_o = claim_q | ~devsel_ni;
  assign timeout_o = active_i && (cnt_q == WIN_C) && !claimed_o;

  a_r3_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= WIN_C);
  a_r3_claim_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_q && !start_i) |=> claim_q);
endmodule

// File: rtl/pci_mst_sts.sv
module pci_mst_sts (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic sts_o
);
  logic sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sts_q <= 1'b0;
    else if (set_i)  sts_q <= 1'b1;
    else if (clr_i)  sts_q <= 1'b0;
  end

  assign sts_o = sts_q;

  a_r4_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> sts_q);
  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q && !clr_i) |=> sts_q);
endmodule

// File: rtl/pci_mst_term.sv
module pci_mst_term
  import pci_mst_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int LAT_W      = 8,
  parameter int DEVSEL_WIN = 5,
  parameter int PAGE_BITS  = 12,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CNT_W-1:0]  req_words_i,
  output logic              req_ack_o,
  input  logic [LAT_W-1:0]  lat_val_i,
  input  logic              gnt_ni,
  input  logic              wbuf_full_i,
  input  logic              devsel_ni,
  input  logic              trdy_ni,
  output logic              frame_no,
  output logic              irdy_no,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2:0]        term_cause_o,
  input  logic              sts_we_i,
  input  logic              sts_wdata_i,
  output logic              mabort_sts_o
);
  localparam int WORD_LSB = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'(WORD_BYTES - 1));

  mst_state_e        state_q, state_d;
  term_cause_e       cause_q, cause_d, sc;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;
  logic              wr_q;
  logic              claimed, timeout, lat_exp, lat_stop;
  logic              active, hs, start;

  // Cause that makes the phase at address a (with r words left) the final one
  function automatic term_cause_e stop_cause(input logic [ADDR_W-1:0] a,
                                             input logic [CNT_W-1:0]  r,
                                             input logic              w,
                                             input logic              full,
                                             input logic              lat);
    if (r <= CNT_W'(1))             return TC_LASTW;
    if (&a[PAGE_BITS-1:WORD_LSB])   return TC_PAGE;
    if (w && full)                  return TC_WBUF;
    if (lat)                        return TC_LAT;
    return TC_NONE;
  endfunction

  assign active   = (state_q == ST_ADDR) || (state_q == ST_DATA) || (state_q == ST_LAST);
  assign hs       = ((state_q == ST_DATA) || (state_q == ST_LAST)) && !trdy_ni && claimed;
  assign start    = req_valid_i &&
                    ((state_q == ST_IDLE) ||
                     ((state_q == ST_LAST) && hs && wr_q && req_write_i));
  assign lat_stop = lat_exp && gnt_ni;

  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    sc      = TC_NONE;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_ADDR;
      ST_ADDR: begin
        sc = stop_cause(addr_q, rem_q, wr_q, wbuf_full_i, lat_stop);
        if (sc != TC_NONE) begin
          state_d = ST_LAST;
          cause_d = sc;
        end else begin
          state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        if (timeout) begin
          state_d = ST_ABORT;
          cause_d = TC_MABORT;
        end else if (hs) begin
          sc = stop_cause(addr_q + STEP, rem_q - CNT_W'(1), wr_q, wbuf_full_i, lat_stop);
          if (sc != TC_NONE) begin
            state_d = ST_LAST;
            cause_d = sc;
          end
        end else if (lat_stop) begin
          // current phase becomes the final one
          state_d = ST_LAST;
          cause_d = TC_LAT;
        end
      end
      ST_LAST: begin
        if (timeout) begin
          state_d = ST_IDLE;
          cause_d = TC_MABORT;
        end else if (hs) begin
          state_d = start ? ST_ADDR : ST_IDLE;
        end
      end
      ST_ABORT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cause_q <= TC_NONE;
      addr_q  <= '0;
      rem_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
      if (start) begin
        addr_q <= req_addr_i & ALIGN_MASK;
        rem_q  <= req_words_i;
        wr_q   <= req_write_i;
      end else if (hs) begin
        addr_q <= addr_q + STEP;
        rem_q  <= rem_q - CNT_W'(1);
      end
    end
  end

  pci_mst_lat_tmr #(.LAT_W(LAT_W)) u_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start),
    .val_i     (lat_val_i),
    .run_i     (active),
    .expired_o (lat_exp)
  );

  pci_mst_dev_mon #(.WIN(DEVSEL_WIN)) u_dev (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .active_i  (active),
    .devsel_ni (devsel_ni),
    .claimed_o (claimed),
    .timeout_o (timeout)
  );

  pci_mst_sts u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (timeout),
    .clr_i  (sts_we_i && sts_wdata_i),
    .sts_o  (mabort_sts_o)
  );

  assign req_ack_o    = start;
  assign frame_no     = !((state_q == ST_ADDR) || (state_q == ST_DATA));
  assign irdy_no      = !((state_q == ST_DATA) || (state_q == ST_LAST) || (state_q == ST_ABORT));
  assign busy_o       = (state_q != ST_IDLE);
  assign addr_o       = addr_q;
  assign term_cause_o = cause_q;

  a_r2_addr_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ack_o |=> (!frame_no && irdy_no));
  a_r2_data_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_no && irdy_no) |=> !irdy_no);
  a_r6_frame_rise_irdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_no) |-> !irdy_no);
  a_r5_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && !start) |=> addr_o == $past(addr_o) + STEP);
  a_r10_irdy_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && frame_no) |=> irdy_no);
  a_r3_abort_unclaimed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mabort_sts_o) |-> $past(devsel_ni));
endmodule

// File: tb/pci_mst_term_tb_top.sv
`timescale 1ns/100ps
module pci_mst_term_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_words = '0;
  logic        req_ack;
  logic [7:0]  lat_val = 8'd255;
  logic        gnt_n = 1'b0, wbuf_full = 1'b0;
  logic        devsel_n = 1'b1, trdy_n = 1'b1;
  logic        frame_n, irdy_n, busy, mabort_sts;
  logic [31:0] addr;
  logic [2:0]  cause;
  logic        sts_we = 1'b0, sts_wdata = 1'b0;

  int checks = 0, fails = 0, cyc = 0;
  int tgt_dly = 2, tgt_ws = 0, tk = 0, bcycles = 0;

  always #2.5 clk = ~clk;

  pci_mst_term dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_words_i(req_words), .req_ack_o(req_ack),
    .lat_val_i(lat_val), .gnt_ni(gnt_n), .wbuf_full_i(wbuf_full),
    .devsel_ni(devsel_n), .trdy_ni(trdy_n), .frame_no(frame_n), .irdy_no(irdy_n),
    .busy_o(busy), .addr_o(addr), .term_cause_o(cause),
    .sts_we_i(sts_we), .sts_wdata_i(sts_wdata), .mabort_sts_o(mabort_sts)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // Target agent: claims at clock tgt_dly, ready every (tgt_ws+1) clocks after
  always @(negedge clk) begin
    if (!busy) tk = 0;
    else if (!frame_n && irdy_n) tk = 1;
    else tk = tk + 1;
    devsel_n <= !(tk > 0 && tk >= tgt_dly);
    trdy_n   <= !(tk > 0 && tk >= tgt_dly && ((tk - tgt_dly) % (tgt_ws + 1)) == 0);
  end

  // Behavioural reference: 0 idle, 1 address, 2 data, 3 final, 4 abort
  int          ms, m_rem, m_k, m_lat, m_cause;
  logic [31:0] m_addr;
  bit          m_wr, m_claim, m_sts;

  function automatic int stop_of(input logic [31:0] a, input int r, input bit w);
    if (r <= 1) return 1;
    if ((a & 32'hFFC) == 32'hFFC) return 2;
    if (w && wbuf_full) return 3;
    if (m_lat == 0 && gnt_n) return 4;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; m_rem = 0; m_k = 0; m_lat = 0; m_cause = 0;
      m_addr = '0; m_wr = 0; m_claim = 0; m_sts = 0;
    end else begin
      bit claim, act, tmo, hs, st;
      int nms, nc, sc;
      claim = m_claim || !devsel_n;
      act   = (ms >= 1 && ms <= 3);
      tmo   = act && m_k == 5 && !claim;
      hs    = (ms == 2 || ms == 3) && !trdy_n && claim;
      st    = req_valid && (ms == 0 || (ms == 3 && hs && m_wr && req_write));
      nms = ms; nc = m_cause;
      case (ms)
        0: if (st) nms = 1;
        1: begin sc = stop_of(m_addr, m_rem, m_wr); nms = (sc != 0) ? 3 : 2; if (sc != 0) nc = sc; end
        2: if (tmo) begin nms = 4; nc = 5; end
           else if (hs) begin
             sc = stop_of(m_addr + 4, m_rem - 1, m_wr);
             if (sc != 0) begin nms = 3; nc = sc; end
           end else if (m_lat == 0 && gnt_n) begin nms = 3; nc = 4; end
        3: if (tmo) begin nms = 0; nc = 5; end
           else if (hs) nms = st ? 1 : 0;
        default: nms = 0;
      endcase
      if (tmo) m_sts = 1;
      else if (sts_we && sts_wdata) m_sts = 0;
      if (st) begin
        m_addr = req_addr & ~32'h3; m_rem = int'(req_words); m_wr = req_write;
        m_k = 1; m_claim = 0; m_lat = int'(lat_val);
      end else begin
        if (hs) begin m_addr = m_addr + 4; m_rem = m_rem - 1; end
        if (act) begin
          m_k = m_k + 1;
          if (!devsel_n) m_claim = 1;
          if (m_lat > 0) m_lat = m_lat - 1;
        end
      end
      ms = nms; m_cause = nc;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 frame_no model", {31'd0, frame_n}, {31'd0, !(ms == 1 || ms == 2)});
      chk("R10 irdy_no model", {31'd0, irdy_n}, {31'd0, !(ms >= 2 && ms <= 4)});
      chk("R2 busy_o model", {31'd0, busy}, {31'd0, ms != 0});
      chk("R5 addr_o model", addr, m_addr);
      chk("R12 term_cause_o model", {29'd0, cause}, 32'(m_cause));
      chk("R4 mabort_sts_o model", {31'd0, mabort_sts}, {31'd0, m_sts});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run(input logic [31:0] a, input int n, input bit w, input int dly, input int ws);
    tgt_dly = dly; tgt_ws = ws;
    req_addr = a; req_words = 16'(n); req_write = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    bcycles = 0;
    while (busy) begin bcycles++; @(negedge clk); end
  endtask

  task automatic sts_write(input bit v);
    sts_we = 1'b1; sts_wdata = v;
    @(negedge clk);
    sts_we = 1'b0; sts_wdata = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 frame_no", {31'd0, frame_n}, 32'd1);
    chk("R1 irdy_no", {31'd0, irdy_n}, 32'd1);
    chk("R1 busy_o", {31'd0, busy}, 32'd0);
    chk("R1 status", {31'd0, mabort_sts}, 32'd0);
    chk("R1 cause", {29'd0, cause}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: address phase then data phase
    tgt_dly = 2; tgt_ws = 0;
    req_addr = 32'h0000_0103; req_words = 16'd4; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 frame_no in address phase", {31'd0, frame_n}, 32'd0);
    chk("R2 irdy_no in address phase", {31'd0, irdy_n}, 32'd1);
    chk("R2 aligned addr_o", addr, 32'h0000_0100);
    @(negedge clk);
    chk("R2 irdy_no in first data phase", {31'd0, irdy_n}, 32'd0);
    while (busy) @(negedge clk);
    chk("R5 address after 4 words", addr, 32'h0000_0110);
    chk("R6 cause last word", {29'd0, cause}, 32'd1);

    // R6 / R10: 4-word read spans 5 busy clocks
    run(32'h0000_0100, 4, 0, 2, 0);
    chk("R10 busy clocks of 4-word read", 32'(bcycles), 32'd5);
    run(32'h0000_0020, 1, 1, 2, 0);
    chk("R6 single write cause", {29'd0, cause}, 32'd1);
    chk("R5 single write addr", addr, 32'h0000_0024);

    // R3 / R4: no claim
    run(32'h0000_0040, 3, 0, 99, 0);
    chk("R3 abort busy clocks", 32'(bcycles), 32'd6);
    chk("R3 abort cause", {29'd0, cause}, 32'd5);
    chk("R4 status set", {31'd0, mabort_sts}, 32'd1);
    chk("R3 no address step", addr, 32'h0000_0040);
    sts_write(1'b0);
    chk("R4 write 0 keeps status", {31'd0, mabort_sts}, 32'd1);
    sts_write(1'b1);
    chk("R4 write 1 clears status", {31'd0, mabort_sts}, 32'd0);
    run(32'h0000_0060, 1, 1, 99, 0);
    chk("R3 abort from final phase clocks", 32'(bcycles), 32'd5);
    chk("R4 status set again", {31'd0, mabort_sts}, 32'd1);
    sts_write(1'b1);

    // R3 window edge
    run(32'h0000_0080, 2, 0, 5, 0);
    chk("R3 claim in clock 5 cause", {29'd0, cause}, 32'd1);
    chk("R3 claim in clock 5 status", {31'd0, mabort_sts}, 32'd0);
    run(32'h0000_0080, 2, 0, 6, 0);
    chk("R3 claim in clock 6 cause", {29'd0, cause}, 32'd5);
    chk("R3 claim in clock 6 busy", 32'(bcycles), 32'd6);
    sts_write(1'b1);

    // R7 page edge
    run(32'h0000_0FF8, 8, 0, 2, 0);
    chk("R7 page cause", {29'd0, cause}, 32'd2);
    chk("R7 page end addr", addr, 32'h0000_1000);
    chk("R7 page busy clocks", 32'(bcycles), 32'd3);

    // R8 buffer full
    wbuf_full = 1'b1;
    run(32'h0000_0200, 8, 1, 2, 0);
    chk("R8 write full cause", {29'd0, cause}, 32'd3);
    chk("R8 write full addr", addr, 32'h0000_0204);
    run(32'h0000_0200, 3, 0, 2, 0);
    chk("R8 read ignores full", {29'd0, cause}, 32'd1);
    chk("R8 read full addr", addr, 32'h0000_020C);
    // R12 priority: page over full, last word over page
    run(32'h0000_0FFC, 4, 1, 2, 0);
    chk("R12 page over full", {29'd0, cause}, 32'd2);
    wbuf_full = 1'b0;
    run(32'h0000_0FFC, 1, 0, 2, 0);
    chk("R12 last word over page", {29'd0, cause}, 32'd1);

    // R9 latency timer
    lat_val = 8'd3; gnt_n = 1'b1;
    run(32'h0000_0400, 16, 0, 2, 3);
    chk("R9 latency cause", {29'd0, cause}, 32'd4);
    chk("R9 latency addr", addr, 32'h0000_0408);
    gnt_n = 1'b0;
    run(32'h0000_0400, 4, 0, 2, 1);
    chk("R9 grant held ignores timer", {29'd0, cause}, 32'd1);
    chk("R9 grant held addr", addr, 32'h0000_0410);
    lat_val = 8'd255;

    // R11 back-to-back writes
    begin
      int idle = 0, naddr = 1;
      tgt_dly = 2; tgt_ws = 0;
      req_addr = 32'h0000_0500; req_words = 16'd2; req_write = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      req_addr = 32'h0000_0600; req_words = 16'd1;
      while (naddr < 2 && idle < 4) begin
        @(negedge clk);
        if (!busy) idle++;
        if (!frame_n && irdy_n) naddr++;
      end
      req_valid = 1'b0;
      while (busy) @(negedge clk);
      chk("R11 no idle clock between writes", 32'(idle), 32'd0);
      chk("R11 second write addr", addr, 32'h0000_0604);
    end

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule